// File: doc/BRIEF.md
# Dual Snapshot Counter with Byte Readout

The block contains two 16-bit binary up-counters, A and B. Each has its own rising-edge clock. A third rising-edge clock, the snapshot clock, copies both live counts into a pair of 16-bit holding registers on the same edge. Because of this, the two values read back always belong to one instant.

The holding registers are read a byte at a time over one shared 8-bit bus. Four active-low select inputs steer the bus: A low byte, A high byte, B low byte and B high byte. The bus is modelled as a data vector plus an output-enable flag rather than a three-state pad.

For a 32-bit count, counter A's active-low terminal-count output is wired to counter B's active-low count enable, and both counters are run from one clock. An active-low asynchronous clear zeroes both counters and leaves the holding registers alone.

The selector is organised as a decoded source state with five named values:
- `SRC_NONE`: the bus is idle.
- `SRC_A_LO` and `SRC_A_HI`: the bus carries the low or high byte of holding register A.
- `SRC_B_LO` and `SRC_B_HI`: the bus carries the low or high byte of holding register B.

The source is re-decoded whenever a select changes. The transition into a given source is taken when its select is the highest-priority low input, and the transition to `SRC_NONE` is taken when all selects are high.

Top module: `dual_snap_counter`

## Requirements
- R1: Counter A increments by one on every rising edge of `clk_a` and wraps from 16'hFFFF to 16'h0000.
- R2: Counter B increments by one on a rising edge of `clk_b` when `cnt_b_en_n` is low, and holds its value when `cnt_b_en_n` is high.
- R3: `carry_a_n` is low exactly while counter A holds 16'hFFFF, and high otherwise.
- R4: While `clr_n` is low, both counters are asynchronously held at zero. The holding registers keep their contents through a clear.
- R5: A rising edge of `clk_snap` copies both counters into holding registers A and B on the same edge. The bus only ever shows holding-register contents.
- R6: With exactly one select low, the bus carries the chosen byte and `bus_oe` is 1. The mapping is: `sel_a_lo_n` gives hold A bits 7:0, `sel_a_hi_n` gives hold A bits 15:8, `sel_b_lo_n` gives hold B bits 7:0, and `sel_b_hi_n` gives hold B bits 15:8.
- R7: With all four selects high, `bus_oe` is 0, `bus_q` is 8'h00 and `sel_clash` is 0.
- R8: With two or more selects low, `bus_oe` is 1 and `sel_clash` is 1. The byte is picked in the priority order A low, A high, B low, B high. With fewer than two selects low, `sel_clash` is 0.
- R9: With `clk_b` driven by the same clock as `clk_a` and `carry_a_n` wired to `cnt_b_en_n`, the pair {B, A} counts as one 32-bit counter. B steps on the edge where A wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Counter A clock, rising edge |
| clk_b | input | 1 | Counter B clock, rising edge |
| clk_snap | input | 1 | Snapshot clock for both holding registers, rising edge |
| clr_n | input | 1 | Asynchronous clear of both counters, active low |
| cnt_b_en_n | input | 1 | Counter B count enable, active low |
| sel_a_lo_n | input | 1 | Select holding A low byte, active low |
| sel_a_hi_n | input | 1 | Select holding A high byte, active low |
| sel_b_lo_n | input | 1 | Select holding B low byte, active low |
| sel_b_hi_n | input | 1 | Select holding B high byte, active low |
| carry_a_n | output | 1 | Counter A terminal count, low while A is all ones |
| bus_q | output | 8 | Shared byte bus data |
| bus_oe | output | 1 | Bus output enable |
| sel_clash | output | 1 | More than one select is low |

## Verification
On every cycle of the relevant clock, the assertions check several properties:
- the single-step behaviour of each counter;
- the hold of counter B when its enable is high;
- the all-ones to terminal-count relation;
- the simultaneous copy into both holding registers;
- the idle-bus, single-select and clash behaviour of the selector.

Some behaviours can only be shown by the bench's scenarios against its reference count model:
- that a clear leaves the holding registers untouched;
- that the bus never shows a live count;
- that the cascaded pair carries into counter B exactly at the 16-bit wrap;

These scenarios run the three clocks at unrelated periods.

// File: rtl/dsc_pkg.sv
`timescale 1ns/10ps
package dsc_pkg;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_A_LO = 3'd1,
        SRC_A_HI = 3'd2,
        SRC_B_LO = 3'd3,
        SRC_B_HI = 3'd4
    } src_e;

endpackage

// File: rtl/dsc_counter.sv
`timescale 1ns/10ps
module dsc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         cnt_en_n,
    output logic [W-1:0] q,
    output logic         term_n
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else if (!cnt_en_n) begin
            q <= q + 1'b1;
        end
    end

    // terminal count is flagged low while every bit is one
    assign term_n = ~(&q);

endmodule

// File: rtl/dsc_snapshot.sv
`timescale 1ns/10ps
module dsc_snapshot #(
    parameter int W = 16
) (
    input  logic         clk_snap,
    input  logic [W-1:0] live_a,
    input  logic [W-1:0] live_b,
    output logic [W-1:0] hold_a,
    output logic [W-1:0] hold_b
);

    // holding registers carry no clear: a counter clear must not touch them
    always_ff @(posedge clk_snap) begin
        hold_a <= live_a;
        hold_b <= live_b;
    end

endmodule

// File: rtl/dsc_byte_sel.sv
`timescale 1ns/10ps
module dsc_byte_sel
    import dsc_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int BYTE_W = CNT_W / 2
) (
    input  logic [CNT_W-1:0]  hold_a,
    input  logic [CNT_W-1:0]  hold_b,
    input  logic [3:0]        sel_n,
    output logic [BYTE_W-1:0] bus_q,
    output logic              bus_oe,
    output logic              clash
);

    src_e src;
    logic [3:0] sel_act;

    assign sel_act = ~sel_n;

    // source decode, fixed priority: A low, A high, B low, B high
    always_comb begin
        if (sel_act[0]) begin
            src = SRC_A_LO;
        end else if (sel_act[1]) begin
            src = SRC_A_HI;
        end else if (sel_act[2]) begin
            src = SRC_B_LO;
        end else if (sel_act[3]) begin
            src = SRC_B_HI;
        end else begin
            src = SRC_NONE;
        end
    end

    // output drive per source
    always_comb begin
        unique case (src)
            SRC_A_LO: begin bus_q = hold_a[BYTE_W-1:0];     bus_oe = 1'b1; end
            SRC_A_HI: begin bus_q = hold_a[CNT_W-1:BYTE_W]; bus_oe = 1'b1; end
            SRC_B_LO: begin bus_q = hold_b[BYTE_W-1:0];     bus_oe = 1'b1; end
            SRC_B_HI: begin bus_q = hold_b[CNT_W-1:BYTE_W]; bus_oe = 1'b1; end
            default:  begin bus_q = '0;                     bus_oe = 1'b0; end
        endcase
    end

    assign clash = ($countones(sel_act) > 1);

endmodule

// File: rtl/dual_snap_counter.sv
`timescale 1ns/10ps
module dual_snap_counter #(
    parameter int CNT_W = 16,
    localparam int BYTE_W = CNT_W / 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              clk_snap,
    input  logic              clr_n,
    input  logic              cnt_b_en_n,
    input  logic              sel_a_lo_n,
    input  logic              sel_a_hi_n,
    input  logic              sel_b_lo_n,
    input  logic              sel_b_hi_n,
    output logic              carry_a_n,
    output logic [BYTE_W-1:0] bus_q,
    output logic              bus_oe,
    output logic              sel_clash
);

    logic [CNT_W-1:0] count_a;
    logic [CNT_W-1:0] count_b;
    logic [CNT_W-1:0] hold_a;
    logic [CNT_W-1:0] hold_b;
    logic [3:0]       sel_n;
    logic             term_b_n;

    assign sel_n = {sel_b_hi_n, sel_b_lo_n, sel_a_hi_n, sel_a_lo_n};

    dsc_counter #(.W(CNT_W)) u_cnt_a (
        .clk      (clk_a),
        .clr_n    (clr_n),
        .cnt_en_n (1'b0),
        .q        (count_a),
        .term_n   (carry_a_n)
    );

    dsc_counter #(.W(CNT_W)) u_cnt_b (
        .clk      (clk_b),
        .clr_n    (clr_n),
        .cnt_en_n (cnt_b_en_n),
        .q        (count_b),
        .term_n   (term_b_n)
    );

    dsc_snapshot #(.W(CNT_W)) u_snap (
        .clk_snap (clk_snap),
        .live_a   (count_a),
        .live_b   (count_b),
        .hold_a   (hold_a),
        .hold_b   (hold_b)
    );

    dsc_byte_sel #(.CNT_W(CNT_W)) u_sel (
        .hold_a (hold_a),
        .hold_b (hold_b),
        .sel_n  (sel_n),
        .bus_q  (bus_q),
        .bus_oe (bus_oe),
        .clash  (sel_clash)
    );

    // counter B terminal count is not a port; keep it observed
    logic unused_term_b;
    assign unused_term_b = term_b_n;

endmodule

// File: rtl/dsc_checker.sv
`timescale 1ns/10ps
module dsc_checker #(
    parameter int CNT_W = 16,
    localparam int BYTE_W = CNT_W / 2
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              clk_snap,
    input logic              clr_n,
    input logic              cnt_b_en_n,
    input logic [3:0]        sel_n,
    input logic [CNT_W-1:0]  count_a,
    input logic [CNT_W-1:0]  count_b,
    input logic [CNT_W-1:0]  hold_a,
    input logic [CNT_W-1:0]  hold_b,
    input logic              carry_a_n,
    input logic [BYTE_W-1:0] bus_q,
    input logic              bus_oe,
    input logic              sel_clash
);

    a_r1_step_a: assert property (@(posedge clk_a) disable iff (!clr_n)
        1'b1 |=> count_a == $past(count_a) + 1'b1);

    a_r2_step_b: assert property (@(posedge clk_b) disable iff (!clr_n)
        !cnt_b_en_n |=> count_b == $past(count_b) + 1'b1);

    a_r2_hold_b: assert property (@(posedge clk_b) disable iff (!clr_n)
        cnt_b_en_n |=> count_b == $past(count_b));

    a_r3_carry_low: assert property (@(posedge clk_a) disable iff (!clr_n)
        (&count_a) |-> !carry_a_n);

    a_r3_carry_high: assert property (@(posedge clk_a) disable iff (!clr_n)
        !(&count_a) |-> carry_a_n);

    a_r5_snap_pair: assert property (@(posedge clk_snap) disable iff (!clr_n)
        1'b1 |=> (hold_a == $past(count_a)) && (hold_b == $past(count_b)));

    a_r6_a_lo_sel: assert property (@(posedge clk_snap) disable iff (!clr_n)
        !sel_n[0] |-> bus_oe && bus_q == hold_a[BYTE_W-1:0]);

    a_r7_idle_bus: assert property (@(posedge clk_snap) disable iff (!clr_n)
        (&sel_n) |-> !bus_oe && bus_q == '0 && !sel_clash);

    a_r8_clash: assert property (@(posedge clk_snap) disable iff (!clr_n)
        ($countones(~sel_n) > 1) |-> sel_clash && bus_oe);

endmodule

bind dual_snap_counter dsc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_a      (clk_a),
    .clk_b      (clk_b),
    .clk_snap   (clk_snap),
    .clr_n      (clr_n),
    .cnt_b_en_n (cnt_b_en_n),
    .sel_n      (sel_n),
    .count_a    (count_a),
    .count_b    (count_b),
    .hold_a     (hold_a),
    .hold_b     (hold_b),
    .carry_a_n  (carry_a_n),
    .bus_q      (bus_q),
    .bus_oe     (bus_oe),
    .sel_clash  (sel_clash)
);

// File: tb/dual_snap_counter_tb.sv
`timescale 1ns/10ps
module dual_snap_counter_tb;

    logic clk_a = 1'b0;
    logic clk_b_free = 1'b0;
    logic clk_snap = 1'b0;
    logic clr_n = 1'b0;
    logic en_free = 1'b0;
    logic cascade = 1'b0;
    logic [3:0] sel_n = 4'hF;   // bit0 A lo, bit1 A hi, bit2 B lo, bit3 B hi
    logic clk_b_drv;
    logic cnt_b_en_n;
    logic carry_a_n;
    logic [7:0] bus_q;
    logic bus_oe;
    logic sel_clash;

    int n_total = 0;
    int n_fail = 0;
    logic chk_on = 1'b0;
    logic finished = 1'b0;

    always #2.0 clk_a = ~clk_a;          // 250 MHz
    always #2.7 clk_b_free = ~clk_b_free;
    always #3.9 clk_snap = ~clk_snap;

    assign clk_b_drv  = cascade ? clk_a : clk_b_free;
    assign cnt_b_en_n = cascade ? carry_a_n : en_free;

    dual_snap_counter u_dut (
        .clk_a      (clk_a),
        .clk_b      (clk_b_drv),
        .clk_snap   (clk_snap),
        .clr_n      (clr_n),
        .cnt_b_en_n (cnt_b_en_n),
        .sel_a_lo_n (sel_n[0]),
        .sel_a_hi_n (sel_n[1]),
        .sel_b_lo_n (sel_n[2]),
        .sel_b_hi_n (sel_n[3]),
        .carry_a_n  (carry_a_n),
        .bus_q      (bus_q),
        .bus_oe     (bus_oe),
        .sel_clash  (sel_clash)
    );

    // behavioural reference model
    logic [15:0] ref_a = '0;
    logic [15:0] ref_b = '0;
    logic [15:0] ref_ha = '0;
    logic [15:0] ref_hb = '0;
    logic [31:0] n_edges = '0;
    logic [31:0] snap_n = '0;

    always @(posedge clk_a or negedge clr_n)
        if (!clr_n) ref_a <= '0; else ref_a <= ref_a + 16'd1;

    always @(posedge clk_b_drv or negedge clr_n)
        if (!clr_n) ref_b <= '0;
        else if (cascade ? (ref_a == 16'hFFFF) : !en_free) ref_b <= ref_b + 16'd1;

    always @(posedge clk_a or negedge clr_n)
        if (!clr_n) n_edges <= '0; else n_edges <= n_edges + 32'd1;

    always @(posedge clk_snap) begin
        ref_ha <= ref_a;
        ref_hb <= ref_b;
        snap_n <= n_edges;
    end

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison of the bus against the model
    always @(negedge clk_snap) begin
        if (chk_on) begin
            logic [7:0] eq;
            logic eoe;
            string tag;
            eoe = 1'b1;
            if (!sel_n[0])      begin eq = ref_ha[7:0];  tag = "R6/R5"; end
            else if (!sel_n[1]) begin eq = ref_ha[15:8]; tag = "R6/R5"; end
            else if (!sel_n[2]) begin eq = ref_hb[7:0];  tag = "R6/R5"; end
            else if (!sel_n[3]) begin eq = ref_hb[15:8]; tag = "R6/R5"; end
            else begin eq = 8'h00; eoe = 1'b0; tag = "R7"; end
            if ($countones(~sel_n) > 1) tag = "R8";
            check_val({tag, " data"}, {24'h0, bus_q}, {24'h0, eq});
            check_val({tag, " oe"}, {31'h0, bus_oe}, {31'h0, eoe});
            check_val({tag, " clash"}, {31'h0, sel_clash}, {31'h0, ($countones(~sel_n) > 1)});
        end
    end

    always @(negedge clk_a) begin
        if (chk_on) check_val("R3 carry", {31'h0, carry_a_n}, {31'h0, (ref_a != 16'hFFFF)});
    end

    task automatic wait_snap(input int n);
        repeat (n) @(posedge clk_snap);
        #0.05;
    endtask

    initial begin
        logic [7:0] v1;
        logic [7:0] held;
        #10;
        // reset state
        check_val("R7 reset oe", {31'h0, bus_oe}, 32'h0);
        check_val("R7 reset data", {24'h0, bus_q}, 32'h0);
        check_val("R8 reset clash", {31'h0, sel_clash}, 32'h0);
        check_val("R3 reset carry", {31'h0, carry_a_n}, 32'h1);
        wait_snap(1);
        clr_n = 1'b1;
        wait_snap(1);
        chk_on = 1'b1;

        // R1 R5 R6: walk each single select
        for (int s = 0; s < 4; s++) begin
            sel_n = ~(4'b0001 << s);
            wait_snap(20);
        end
        sel_n = 4'hF;
        wait_snap(5);

        // R8: multiple selects
        sel_n = 4'b0110;  // A lo and B hi
        wait_snap(5);
        check_val("R8 clash A lo wins", {31'h0, sel_clash}, 32'h1);
        sel_n = 4'b1001;  // A hi and B lo
        wait_snap(5);
        sel_n = 4'b0011;  // B lo and B hi
        wait_snap(5);
        sel_n = 4'b0000;
        wait_snap(5);

        // R2: counter B hold while enable is high
        sel_n = 4'b1011;  // B lo
        en_free = 1'b1;
        wait_snap(2);
        v1 = bus_q;
        wait_snap(10);
        check_val("R2 hold", {24'h0, bus_q}, {24'h0, v1});
        en_free = 1'b0;
        wait_snap(3);
        check_val("R2 resume", {31'h0, (bus_q != v1)}, 32'h1);

        // R4: clear leaves holding registers alone
        sel_n = 4'b1110;  // A lo
        wait_snap(1);
        held = ref_ha[7:0];
        clr_n = 1'b0;
        #0.5;
        check_val("R4 hold kept", {24'h0, bus_q}, {24'h0, held});
        check_val("R4 hold nonzero", {31'h0, (held != 8'h00)}, 32'h1);
        wait_snap(1);
        check_val("R4 cleared", {24'h0, bus_q}, 32'h0);

        // R9: cascade across the 16-bit wrap (R1 wrap too)
        cascade = 1'b1;
        wait_snap(1);
        clr_n = 1'b1;
        sel_n = 4'b1011;  // B lo
        repeat (66000) @(posedge clk_a);
        wait_snap(2);
        check_val("R9 B low byte", {24'h0, bus_q}, {24'h0, snap_n[23:16]});
        check_val("R9 past wrap", {31'h0, (snap_n >= 32'h10000)}, 32'h1);
        sel_n = 4'b1110;  // A lo
        #0.5;
        check_val("R9 A low byte", {24'h0, bus_q}, {24'h0, snap_n[7:0]});
        sel_n = 4'b1101;  // A hi
        #0.5;
        check_val("R9 A high byte", {24'h0, bus_q}, {24'h0, snap_n[15:8]});
        wait_snap(2);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule